// File: doc/BRIEF.md
# Binary-Stepped Dilation Shift Array

This block holds a small two-dimensional grid of feature-map pixels and presents a 3×3 window of them to a convolution datapath after the grid has been displaced by a programmable dilation rate in one of four directions. The displacement is not done in a single wide shifter. A cascade of stages each moves the whole grid by either nothing or by a fixed power-of-two distance (1, 2, 4, ...). Stage h is steered by bit h of the rate, so any rate from 1 to 2^N−1 costs the same N register stages. The time per window therefore does not depend on the rate, and a standard convolution (rate 1) runs at the same speed as a dilated one.

Pixels are written one row per cycle through a row-parallel load port. The dilation rate is latched only while that load port is active, so it changes once per layer while the array is idle. Each accepted step request carries a direction. The request travels down the stage pipeline together with the rate it was accepted with, and N cycles later the window appears at the output with a valid strobe. Cells that would come from beyond the grid edge arrive as zero. Steps may be issued on consecutive cycles, and the windows then leave on consecutive cycles.

Top module: `dil_shift_array`

## Requirements
- R1: After reset, win_valid is 0, every tap is 0 and the latched rate is 1.
- R2: While load_en is 1, load_data is written into grid row load_row, with column c taken from bits [c*PIX_W +: PIX_W]. A load_row value of ROWS or more changes no row. While load_en is 0 the grid is unchanged.
- R3: cfg_rate is latched only when cfg_we and load_en are both 1 and cfg_rate is nonzero. A write with load_en at 0 or with a zero value keeps the previous rate.
- R4: A step is accepted when step_valid is 1 and load_en is 0. Its window is shown with win_valid at 1 exactly N_STAGES cycles later. Back-to-back steps give back-to-back windows for every rate.
- R5: With rate D, the shifted grid S is derived from the loaded grid G according to step_dir. For code 0 (up), S(r,c)=G(r+D,c). For code 1 (right), S(r,c)=G(r,c−D). For code 2 (down), S(r,c)=G(r−D,c). For code 3 (left), S(r,c)=G(r,c+D).
- R6: Any S(r,c) whose source lies outside the grid is 0.
- R7: Tap (a,b), with a and b in 0..TAP−1, sits at win_taps bits [(a*TAP+b)*PIX_W +: PIX_W] and equals S(a,b).
- R8: A step raised while load_en is 1 produces no window.
- R9: A window uses the rate and pixels that were present when its step was accepted. A load or rate change in the following cycles does not alter it.
- R10: When win_valid is 0, win_taps keeps the last window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Row load enable; also opens the rate latch and blocks steps |
| load_row | input | $clog2(ROWS) | Row written while load_en is 1 |
| load_data | input | COLS*PIX_W | Pixels of one row, column 0 in the low bits |
| cfg_we | input | 1 | Rate write strobe |
| cfg_rate | input | N_STAGES | Dilation rate, 1 to 2^N_STAGES−1 |
| step_valid | input | 1 | Request one shifted window |
| step_dir | input | 2 | 0 up, 1 right, 2 down, 3 left |
| win_valid | output | 1 | Window on win_taps is new this cycle |
| win_taps | output | TAP*TAP*PIX_W | Tap window, tap (a,b) at index a*TAP+b |

## Verification
Reconfiguration and windows in flight can fall in the same cycle: a step is accepted, and on the next cycle load_en rises with a new rate and a new row 0 while that step's window is still inside the stages. The bench provokes this and compares the emerging window against one computed from the old grid and old rate. It then issues a fresh step to confirm that the new row and rate did land. Step requests made while load_en is high form a second collision, and they must leave win_valid low and the taps frozen.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic [1:0] {
    DIR_UP    = 2'd0,
    DIR_RIGHT = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_LEFT  = 2'd3
  } dir_e;
endpackage

// File: rtl/dsa_base_grid.sv
module dsa_base_grid #(
  parameter int ROWS  = 6,
  parameter int COLS  = 6,
  parameter int PIX_W = 8,
  parameter int ROW_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_en,
  input  logic [ROW_W-1:0]           load_row,
  input  logic [COLS*PIX_W-1:0]      load_data,
  output logic [ROWS*COLS*PIX_W-1:0] grid_q
);
  localparam int RW = COLS * PIX_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_q <= '0;
    end else if (load_en) begin
      for (int r = 0; r < ROWS; r++) begin
        if (int'(load_row) == r) grid_q[r*RW +: RW] <= load_data;
      end
    end
  end

  // R2: the grid only moves under load_en
  p_grid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(grid_q));
endmodule

// File: rtl/dsa_rate_cfg.sv
module dsa_rate_cfg #(
  parameter int N_STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic                cfg_we,
  input  logic [N_STAGES-1:0] cfg_rate,
  output logic [N_STAGES-1:0] rate_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= N_STAGES'(1);
    end else if (load_en && cfg_we && (cfg_rate != '0)) begin
      rate_q <= cfg_rate;
    end
  end

  p_rate_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    rate_q != '0);

  p_rate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(rate_q));
endmodule

// File: rtl/dsa_stage.sv
module dsa_stage
  import dsa_pkg::*;
#(
  parameter int ROWS     = 6,
  parameter int COLS     = 6,
  parameter int PIX_W    = 8,
  parameter int N_STAGES = 3,
  parameter int IDX      = 0,
  parameter int OUT_R    = 6,
  parameter int OUT_C    = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic [1:0]                   in_dir,
  input  logic [N_STAGES-1:0]          in_rate,
  input  logic [ROWS*COLS*PIX_W-1:0]   in_grid,
  output logic                         out_vld,
  output logic [1:0]                   out_dir,
  output logic [N_STAGES-1:0]          out_rate,
  output logic [OUT_R*OUT_C*PIX_W-1:0] out_grid
);
  localparam int DIST = 1 << IDX;
  localparam int OW   = OUT_R * OUT_C * PIX_W;

  logic [OW-1:0] hd_g, up_g, rt_g, dn_g, lf_g, nx_g;

  for (genvar r = 0; r < OUT_R; r++) begin : g_row
    for (genvar c = 0; c < OUT_C; c++) begin : g_col
      localparam int OB = (r * OUT_C + c) * PIX_W;
      assign hd_g[OB +: PIX_W] = in_grid[(r*COLS+c)*PIX_W +: PIX_W];
      if (r + DIST < ROWS) begin : g_up
        assign up_g[OB +: PIX_W] = in_grid[((r+DIST)*COLS+c)*PIX_W +: PIX_W];
      end else begin : g_up0
        assign up_g[OB +: PIX_W] = '0;
      end
      if (c >= DIST) begin : g_rt
        assign rt_g[OB +: PIX_W] = in_grid[(r*COLS+c-DIST)*PIX_W +: PIX_W];
      end else begin : g_rt0
        assign rt_g[OB +: PIX_W] = '0;
      end
      if (r >= DIST) begin : g_dn
        assign dn_g[OB +: PIX_W] = in_grid[((r-DIST)*COLS+c)*PIX_W +: PIX_W];
      end else begin : g_dn0
        assign dn_g[OB +: PIX_W] = '0;
      end
      if (c + DIST < COLS) begin : g_lf
        assign lf_g[OB +: PIX_W] = in_grid[(r*COLS+c+DIST)*PIX_W +: PIX_W];
      end else begin : g_lf0
        assign lf_g[OB +: PIX_W] = '0;
      end
    end
  end

  always_comb begin
    nx_g = hd_g;
    if (in_rate[IDX]) begin
      case (dir_e'(in_dir))
        DIR_UP:    nx_g = up_g;
        DIR_RIGHT: nx_g = rt_g;
        DIR_DOWN:  nx_g = dn_g;
        DIR_LEFT:  nx_g = lf_g;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_dir  <= '0;
      out_rate <= '0;
      out_grid <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_dir  <= in_dir;
        out_rate <= in_rate;
        out_grid <= nx_g;
      end
    end
  end

  // R10: a stage without a request keeps its contents
  p_stage_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_grid));
endmodule

// File: rtl/dil_shift_array.sv
module dil_shift_array
  import dsa_pkg::*;
#(
  parameter int ROWS     = 6,
  parameter int COLS     = 6,
  parameter int PIX_W    = 8,
  parameter int N_STAGES = 3,
  parameter int TAP      = 3,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int GW      = ROWS * COLS * PIX_W,
  localparam int WW      = TAP * TAP * PIX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_en,
  input  logic [ROW_W-1:0]      load_row,
  input  logic [COLS*PIX_W-1:0] load_data,
  input  logic                  cfg_we,
  input  logic [N_STAGES-1:0]   cfg_rate,
  input  logic                  step_valid,
  input  logic [1:0]            step_dir,
  output logic                  win_valid,
  output logic [WW-1:0]         win_taps
);
  logic [GW-1:0]         base_q;
  logic [N_STAGES-1:0]   rate_q;

  logic [N_STAGES-1:0]                 s_vld;
  logic [N_STAGES-1:0][1:0]            s_dir;
  logic [N_STAGES-1:0][N_STAGES-1:0]   s_rate;
  logic [N_STAGES-1:0][GW-1:0]         s_grid;

  logic                  dir_vld_l;
  logic [1:0]            dir_l;
  logic [N_STAGES-1:0]   rate_l;

  dsa_base_grid #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .ROW_W(ROW_W)) base_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_row(load_row),
    .load_data(load_data), .grid_q(base_q)
  );

  dsa_rate_cfg #(.N_STAGES(N_STAGES)) cfg_i (
    .clk(clk), .rst(rst), .load_en(load_en), .cfg_we(cfg_we),
    .cfg_rate(cfg_rate), .rate_q(rate_q)
  );

  assign s_vld[0]  = step_valid & ~load_en;
  assign s_dir[0]  = step_dir;
  assign s_rate[0] = rate_q;
  assign s_grid[0] = base_q;

  for (genvar h = 0; h < N_STAGES; h++) begin : g_stage
    if (h < N_STAGES - 1) begin : g_mid
      dsa_stage #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .N_STAGES(N_STAGES),
                  .IDX(h), .OUT_R(ROWS), .OUT_C(COLS)) stage_i (
        .clk(clk), .rst(rst),
        .in_vld(s_vld[h]), .in_dir(s_dir[h]), .in_rate(s_rate[h]), .in_grid(s_grid[h]),
        .out_vld(s_vld[h+1]), .out_dir(s_dir[h+1]), .out_rate(s_rate[h+1]),
        .out_grid(s_grid[h+1])
      );
    end else begin : g_last
      dsa_stage #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .N_STAGES(N_STAGES),
                  .IDX(h), .OUT_R(TAP), .OUT_C(TAP)) stage_i (
        .clk(clk), .rst(rst),
        .in_vld(s_vld[h]), .in_dir(s_dir[h]), .in_rate(s_rate[h]), .in_grid(s_grid[h]),
        .out_vld(dir_vld_l), .out_dir(dir_l), .out_rate(rate_l),
        .out_grid(win_taps)
      );
    end
  end

  assign win_valid = dir_vld_l;

  // R3: every emitted window was formed with a nonzero rate
  p_win_rate_r3: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> rate_l != '0);

  for (genvar a = 0; a < TAP; a++) begin : g_fill_chk
    // R6: a right move of at least one leaves tap column 0 empty
    p_right_fill_r6: assert property (@(posedge clk) disable iff (rst)
      (win_valid && dir_e'(dir_l) == DIR_RIGHT) |-> win_taps[(a*TAP)*PIX_W +: PIX_W] == '0);
    // R6: a down move of at least one leaves tap row 0 empty
    p_down_fill_r6: assert property (@(posedge clk) disable iff (rst)
      (win_valid && dir_e'(dir_l) == DIR_DOWN) |-> win_taps[a*PIX_W +: PIX_W] == '0);
  end
endmodule

// File: tb/dil_shift_array_tb_top.sv
module dil_shift_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 6;
  localparam int COLS  = 6;
  localparam int PIX_W = 8;
  localparam int NS    = 3;
  localparam int TAP   = 3;

  logic clk = 1'b0;
  logic rst;
  logic load_en;
  logic [2:0] load_row;
  logic [COLS*PIX_W-1:0] load_data;
  logic cfg_we;
  logic [NS-1:0] cfg_rate;
  logic step_valid;
  logic [1:0] step_dir;
  logic win_valid;
  logic [TAP*TAP*PIX_W-1:0] win_taps;

  int n_chk = 0;
  int n_bad = 0;
  int model [ROWS][COLS];
  int cur_rate;

  always #(CLK_PERIOD/2) clk = ~clk;

  dil_shift_array #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .N_STAGES(NS), .TAP(TAP)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_row(load_row), .load_data(load_data),
    .cfg_we(cfg_we), .cfg_rate(cfg_rate), .step_valid(step_valid), .step_dir(step_dir),
    .win_valid(win_valid), .win_taps(win_taps)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int seed, input int r, input int c);
    return ((seed * 29 + r * COLS + c) % 250) + 1;
  endfunction

  function automatic int exp_pix(input int dir, input int d, input int r, input int c);
    int sr = r;
    int sc = c;
    case (dir)
      0: sr = r + d;
      1: sc = c - d;
      2: sr = r - d;
      default: sc = c + d;
    endcase
    if (sr < 0 || sr >= ROWS || sc < 0 || sc >= COLS) return 0;
    return model[sr][sc];
  endfunction

  function automatic int tap(input int a, input int b);
    return int'(win_taps[(a*TAP+b)*PIX_W +: PIX_W]);
  endfunction

  task automatic load_grid(input int seed);
    for (int r = 0; r < ROWS; r++) begin
      load_en = 1'b1;
      load_row = 3'(r);
      for (int c = 0; c < COLS; c++) begin
        load_data[c*PIX_W +: PIX_W] = 8'(pat(seed, r, c));
        model[r][c] = pat(seed, r, c);
      end
      @(negedge clk);
    end
    load_en = 1'b0;
  endtask

  // writes junk to a nonexistent row at the same time (R2 ignore)
  task automatic set_rate(input int rt);
    load_en = 1'b1;
    cfg_we = 1'b1;
    cfg_rate = NS'(rt);
    load_row = 3'd7;
    load_data = '1;
    @(negedge clk);
    load_en = 1'b0;
    cfg_we = 1'b0;
    if (rt != 0) cur_rate = rt;
  endtask

  task automatic check_win(input int dir, input string req);
    chk(win_valid == 1'b1, req, int'(win_valid), 1);
    for (int a = 0; a < TAP; a++)
      for (int b = 0; b < TAP; b++)
        chk(tap(a, b) == exp_pix(dir, cur_rate, a, b), req, tap(a, b), exp_pix(dir, cur_rate, a, b));
  endtask

  task automatic run_step(input int dir, input string req);
    step_valid = 1'b1;
    step_dir = 2'(dir);
    @(negedge clk);
    step_valid = 1'b0;
    repeat (NS - 1) @(negedge clk);
    check_win(dir, req);
    @(negedge clk);
    chk(win_valid == 1'b0, "R4 single pulse", int'(win_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_w [TAP][TAP];
    logic [TAP*TAP*PIX_W-1:0] held;
    rst = 1'b1; load_en = 1'b0; load_row = '0; load_data = '0;
    cfg_we = 1'b0; cfg_rate = '0; step_valid = 1'b0; step_dir = '0;
    cur_rate = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(win_valid == 1'b0, "R1 valid", int'(win_valid), 0);
    chk(win_taps == '0, "R1 taps", int'(win_taps[31:0]), 0);
    load_grid(1);
    run_step(0, "R1 default rate");
    // R2: rows map as loaded, junk row 7 left no trace
    set_rate(3);
    run_step(0, "R2 row mapping");
    // sweep every rate and direction
    for (int rt = 1; rt < (1 << NS); rt++) begin
      set_rate(rt);
      for (int d = 0; d < 4; d++) run_step(d, "R5/R6/R7 sweep");
    end
    // R3: writes outside a load or of zero are ignored
    load_grid(3);
    set_rate(2);
    cfg_we = 1'b1; cfg_rate = 3'd5;
    @(negedge clk);
    cfg_we = 1'b0;
    run_step(0, "R3 write without load");
    set_rate(0);
    run_step(3, "R3 zero rate");
    // R8: step under load_en gives nothing; R10 taps hold
    held = win_taps;
    load_en = 1'b1; load_row = 3'd7; load_data = '1; step_valid = 1'b1; step_dir = 2'd0;
    @(negedge clk);
    load_en = 1'b0; step_valid = 1'b0;
    for (int k = 0; k < NS + 1; k++) begin
      chk(win_valid == 1'b0, "R8 step during load", int'(win_valid), 0);
      @(negedge clk);
    end
    chk(win_taps == held, "R10 taps held", int'(win_taps[31:0]), int'(held[31:0]));
    // R4: back-to-back steps stream out
    set_rate(1);
    @(negedge clk);
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          step_valid = 1'b1; step_dir = 2'(k);
          @(negedge clk);
        end
        step_valid = 1'b0;
      end
      begin
        repeat (NS) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          check_win(k, "R4 back-to-back");
          @(negedge clk);
        end
        chk(win_valid == 1'b0, "R4 stream end", int'(win_valid), 0);
      end
    join
    // R9: reload and rate change while a window is in flight
    set_rate(2);
    for (int a = 0; a < TAP; a++)
      for (int b = 0; b < TAP; b++) exp_w[a][b] = exp_pix(3, 2, a, b);
    step_valid = 1'b1; step_dir = 2'd3;
    @(negedge clk);
    step_valid = 1'b0;
    load_en = 1'b1; cfg_we = 1'b1; cfg_rate = 3'd1; load_row = 3'd0;
    for (int c = 0; c < COLS; c++) load_data[c*PIX_W +: PIX_W] = 8'hEE;
    @(negedge clk);
    load_en = 1'b0; cfg_we = 1'b0;
    repeat (NS - 2) @(negedge clk);
    chk(win_valid == 1'b1, "R9 in-flight valid", int'(win_valid), 1);
    for (int a = 0; a < TAP; a++)
      for (int b = 0; b < TAP; b++)
        chk(tap(a, b) == exp_w[a][b], "R9 in-flight window", tap(a, b), exp_w[a][b]);
    @(negedge clk);
    for (int c = 0; c < COLS; c++) model[0][c] = 8'hEE;
    cur_rate = 1;
    run_step(2, "R9 update landed");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule